// File: doc/BRIEF.md
# Sequential Signed Fractional Multiplier

This block multiplies two 25-bit signed fractions, one multiplier bit per clock. Each operand uses a sign bit followed by 24 fraction bits, with the binary point just right of the sign bit. The representable range is therefore -1.0 up to 1 - 2^-24.

The multiplier operand is loaded into a shift register and read from its sign bit downward. The sign bit has weight -1. When it is set, the multiplicand is subtracted from a sign-extended 28-bit accumulator. The subtraction is an add of the inverted multiplicand with a carry-in of one. Each later bit has weight 2^-k. When that bit is set, the multiplicand, arithmetically shifted right by k places, is added. No correction step is applied at the end.

The product is read from the accumulator bits aligned to the binary point, and the bits shifted out below the least significant position are discarded. The one result that does not fit (-1.0 times -1.0) is clamped to the largest positive value and flagged.

A caller raises `start` with both operands while the block is idle. It then waits for the one-cycle `done` pulse and reads `product` and `ovf`. Both outputs hold until the next result is written.

Top module: `frac_seq_mul`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `ovf` and `product` are all zero until the first result.
- R2: When `start` is high at a clock edge while `busy` is low, that edge accepts the operands. `busy` is then high for the following 26 cycles. `done` is high only in the cycle after the 26th edge following the accepting edge.
- R3: A `start` pulse, with any operand values, that arrives while `busy` is high has no effect. The pending result, its timing and the count of `done` pulses are unchanged.
- R4: Multiplier bit 24 (the sign, weight -1) causes the multiplicand to be subtracted. For example, 0.5 (0x0800000) times -1.0 (0x1000000) gives -0.5 (0x1800000).
- R5: Multiplier bit 24-k (for k = 1..24, weight 2^-k) adds the multiplicand arithmetically shifted right by k, with each shifted term rounded toward minus infinity. The product is the sum of all selected terms, in two's complement with 24 fraction bits.
- R6: A non-negative multiplier gives the R5 sum with no correction, including for negative multiplicands.
- R7: If the sum exceeds 0x0FFFFFF as a signed value, `product` is 0x0FFFFFF and `ovf` is 1. If it is below -1.0, `product` is 0x1000000 and `ovf` is 1. Otherwise `ovf` is 0. Only 0x1000000 times 0x1000000 overflows.
- R8: `product` and `ovf` change only in the cycle where `done` is high, and they hold between results.
- R9: A `start` given in the same cycle that `done` is high is accepted. It begins a new operation with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand_i | input | 25 | Multiplicand, signed fraction |
| mplier_i | input | 25 | Multiplier, signed fraction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| product | output | 25 | Truncated, clamped product |
| ovf | output | 1 | Result was clamped |

## Verification
Two functions can fall in the same cycle: the completion strobe of one operation and the acceptance of the next. The bench's driver waits only for `busy` to drop before raising `start`, and `busy` first drops in the `done` cycle. Every queued operation is therefore issued in the completion cycle of the one before it. At the moment of issue, the bench confirms that `done` is high. The monitor then checks two things independently for each result. First, the earlier result is the one that arrives at that strobe. Second, the new result keeps the full 26-edge latency measured from its own acceptance.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    FM_IDLE = 2'd0,
    FM_RUN  = 2'd1,
    FM_FIN  = 2'd2
  } fm_state_e;

  // guard bits above the sign so no partial sum can wrap
  localparam int unsigned FM_EXT_BITS = 3;
endpackage

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int unsigned NBITS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic first,
  output logic finish,
  output logic busy
);
  localparam int unsigned CW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  fm_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      FM_IDLE: begin
        if (start) begin
          st_d   = FM_RUN;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      FM_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          st_d  = FM_FIN;
          cnt_d = '0;
        end
      end
      FM_FIN:  st_d = FM_IDLE;
      default: st_d = FM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FM_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign load   = (st_q == FM_IDLE) && start;
  assign step   = (st_q == FM_RUN);
  assign first  = (st_q == FM_RUN) && (cnt_q == '0);
  assign finish = (st_q == FM_FIN);
  assign busy   = (st_q != FM_IDLE);
endmodule

// File: rtl/fm_addsub.sv
module fm_addsub #(
  parameter int unsigned W = 28
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] term,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W-1:0] term_x;
  logic [W-1:0] cin;

  // inverting the term and injecting a carry of one negates it
  assign term_x = term ^ {W{sub}};
  assign cin    = {{(W-1){1'b0}}, sub};
  assign sum    = acc + term_x + cin;
endmodule

// File: rtl/fm_clamp.sv
module fm_clamp #(
  parameter int unsigned AW       = 28,
  parameter int unsigned DW       = 25,
  parameter bit          SATURATE = 1'b1
) (
  input  logic [AW-1:0] acc,
  output logic [DW-1:0] res,
  output logic          ovf
);
  localparam int unsigned HW = AW - DW + 1;

  logic [HW-1:0] head;
  assign head = acc[AW-1:DW-1];
  // the stored sign must agree with every guard bit above it
  assign ovf  = !((&head) || !(|head));

  generate
    if (SATURATE) begin : g_sat
      assign res = ovf ? {acc[AW-1], {(DW-1){~acc[AW-1]}}} : acc[DW-1:0];
    end else begin : g_wrap
      assign res = acc[DW-1:0];
    end
  endgenerate
endmodule

// File: rtl/frac_seq_mul.sv
module frac_seq_mul
  import fm_pkg::*;
#(
  parameter int unsigned DW       = 25,
  parameter int unsigned EXT      = FM_EXT_BITS,
  parameter bit          SATURATE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] mcand_i,
  input  logic [DW-1:0] mplier_i,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] product,
  output logic          ovf
);
  localparam int unsigned AW = DW + EXT;

  logic load, step, first, finish;
  logic dat_en, out_en;

  logic [DW-1:0] mpl_q, mpl_d;
  logic [AW-1:0] mcs_q, mcs_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [DW-1:0] prod_q, prod_d;
  logic          ovf_q, ovf_d;
  logic          done_q, done_d;

  logic [AW-1:0] sum;
  logic [DW-1:0] clamp_res;
  logic          clamp_ovf;

  fm_ctrl #(.NBITS(DW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .load   (load),
    .step   (step),
    .first  (first),
    .finish (finish),
    .busy   (busy)
  );

  // first step handles the negative-weight sign bit: subtract
  fm_addsub #(.W(AW)) u_addsub (
    .acc  (acc_q),
    .term (mcs_q),
    .sub  (first),
    .sum  (sum)
  );

  fm_clamp #(.AW(AW), .DW(DW), .SATURATE(SATURATE)) u_clamp (
    .acc (acc_q),
    .res (clamp_res),
    .ovf (clamp_ovf)
  );

  assign dat_en = load | step;
  assign out_en = finish;

  always_comb begin
    mpl_d = mpl_q;
    mcs_d = mcs_q;
    acc_d = acc_q;
    if (load) begin
      mpl_d = mplier_i;
      mcs_d = {{EXT{mcand_i[DW-1]}}, mcand_i};
      acc_d = '0;
    end else if (step) begin
      if (mpl_q[DW-1]) acc_d = sum;
      mpl_d = {mpl_q[DW-2:0], 1'b0};
      mcs_d = {mcs_q[AW-1], mcs_q[AW-1:1]};
    end
    prod_d = clamp_res;
    ovf_d  = clamp_ovf;
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpl_q  <= '0;
      mcs_q  <= '0;
      acc_q  <= '0;
      prod_q <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (dat_en) begin
        mpl_q <= mpl_d;
        mcs_q <= mcs_d;
        acc_q <= acc_d;
      end
      if (out_en) begin
        prod_q <= prod_d;
        ovf_q  <= ovf_d;
      end
      done_q <= done_d;
    end
  end

  assign product = prod_q;
  assign ovf     = ovf_q;
  assign done    = done_q;
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int unsigned DW       = 25,
  parameter bit          SATURATE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] product,
  input logic          ovf
);
  localparam int unsigned RUN_LEN = DW + 1;
  localparam int unsigned CW      = $clog2(RUN_LEN + 2);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy && (run_q != {CW{1'b1}})) run_q <= run_q + 1'b1;
    else if (!busy) run_q <= '0;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // also catches a restart by a start pulse during busy (R3)
  p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == CW'(RUN_LEN)));

  p_done_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(product) && $stable(ovf)));

  generate
    if (SATURATE) begin : g_sat_chk
      p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ((product == {1'b0, {(DW-1){1'b1}}}) ||
                 (product == {1'b1, {(DW-1){1'b0}}})));
    end
  endgenerate
endmodule

bind frac_seq_mul fm_checker #(.DW(DW), .SATURATE(SATURATE)) u_fm_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product),
  .ovf     (ovf)
);

// File: tb/frac_seq_mul_bench.sv
`timescale 1ns/1ps
module frac_seq_mul_bench;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [24:0] mcand;
  logic [24:0] mplier;
  logic        busy, done, ovf;
  logic [24:0] product;

  typedef struct {
    logic [24:0] prod;
    logic        ovf;
    string       req;
    longint      t0;
  } item_t;

  item_t  exp_q[$];
  int     total = 0;
  int     fails = 0;
  longint cyc = 0;
  logic [24:0] last_prod;
  logic        last_ovf;

  frac_seq_mul u_frac_seq_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .busy     (busy),
    .done     (done),
    .product  (product),
    .ovf      (ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // independent model of the requirement arithmetic
  task automatic model(input logic [24:0] a, input logic [24:0] b,
                       output logic [24:0] p, output logic o);
    longint sa;
    longint acc;
    sa  = longint'($signed(a));
    acc = 0;
    if (b[24]) acc = -sa;
    for (int k = 1; k < 25; k++) if (b[24-k]) acc = acc + (sa >>> k);
    if (acc > 64'sd16777215) begin
      p = 25'h0FFFFFF; o = 1'b1;
    end else if (acc < -64'sd16777216) begin
      p = 25'h1000000; o = 1'b1;
    end else begin
      p = acc[24:0]; o = 1'b0;
    end
  endtask

  task automatic issue(input logic [24:0] a, input logic [24:0] b, input string req);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    if (req == "R9") chk(done == 1'b1, "R9", "start not in done cycle", 64'(done), 64'd1);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    model(a, b, it.prod, it.ovf);
    it.req = req;
    it.t0  = cyc;
    exp_q.push_back(it);
    @(negedge clk);
    start  = 1'b0;
    mcand  = ~a;
    mplier = ~b;
  endtask

  // monitor: compares each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected done", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(product == it.prod, it.req, "product", 64'(product), 64'(it.prod));
        chk(ovf == it.ovf, "R7", "ovf", 64'(ovf), 64'(it.ovf));
        chk((cyc - it.t0) == 27, "R2", "latency", 64'(cyc - it.t0), 64'd27);
        last_prod = it.prod;
        last_ovf  = it.ovf;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n  = 1'b0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(busy == 0, "R1", "busy", 64'(busy), 64'd0);
    chk(done == 0, "R1", "done", 64'(done), 64'd0);
    chk(product == 0, "R1", "product", 64'(product), 64'd0);
    chk(ovf == 0, "R1", "ovf", 64'(ovf), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && product == 0 && ovf == 0, "R1", "after release",
        64'({busy, done, ovf, product}), 64'd0);

    issue(25'h0C00000, 25'h0D00000, "R5");  // 0.75 * 0.8125
    issue(25'h0800000, 25'h0800000, "R5");  // 0.5 * 0.5
    issue(25'h0800000, 25'h1000000, "R4");  // 0.5 * -1
    issue(25'h1C00000, 25'h1800000, "R4");  // -0.25 * -0.5
    issue(25'h1400000, 25'h0400000, "R6");  // -0.75 * 0.25
    issue(25'h1FFFFFF, 25'h0FFFFFF, "R6");  // smallest negative * max
    issue(25'h1000000, 25'h1000000, "R7");  // -1 * -1 clamps
    issue(25'h1000000, 25'h1000001, "R7");  // just below the limit
    issue(25'h0FFFFFF, 25'h0FFFFFF, "R5");
    issue(25'h1000000, 25'h0FFFFFF, "R6");
    issue(25'h0123456, 25'h0000000, "R5");
    issue(25'h0ABCDEF, 25'h1234567, "R9");

    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 20; i++) begin
      logic [24:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[24:0];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr[31:7];
      issue(a, b, "R5");
    end

    // R3: a start while busy must be ignored
    issue(25'h0600000, 25'h0300000, "R3");
    repeat (6) @(negedge clk);
    chk(busy == 1, "R3", "busy before stray start", 64'(busy), 64'd1);
    mcand  = 25'h1000000;
    mplier = 25'h1000000;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(busy == 0, "R3", "no restart", 64'(busy), 64'd0);

    // R8: outputs hold while idle
    chk(product == last_prod, "R8", "product held", 64'(product), 64'(last_prod));
    chk(ovf == last_ovf, "R8", "ovf held", 64'(ovf), 64'(last_ovf));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule